// File: doc/BRIEF.md
# Virtual Segment ID Scrambler

This block turns a translation request into a scrambled virtual segment identifier. A request carries a 19-bit context number, a 64-bit effective address, a segment-size select and a kernel flag. The block joins the context with the segment number taken from the address to form a proto-ID. It then multiplies the proto-ID by a fixed 24-bit prime and reduces the product modulo 2^n - 1. The reduction uses an end-around fold with one carry correction, so no divider is needed. Because the multiplier is coprime to the modulus, the mapping is one-to-one and spreads neighbouring segments across the whole ID space.

In kernel mode the context input is ignored. The context is instead taken from the four-bit region at the top of the address, so that regions 0xC to 0xF map to the four highest context numbers. Two kinds of request produce an ID of zero: an address whose offset lies beyond the translatable range, and a user context above the largest user context. The second kind also raises an error flag.

The block is fully pipelined. It accepts one request per cycle and delivers the result three cycles later, with a valid bit that travels alongside the data.

Top module: `segid_scrambler`

## Requirements
- R1: While reset is asserted, `req_ready` and `res_valid` are 0. `req_ready` rises at the first clock edge after reset is released and stays high from then on.
- R2: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Its result appears with `res_valid` high exactly three edges later. A new request is accepted every cycle, and `res_valid` is 0 in every cycle that has no matching request.
- R3: When `req_big`=0 (256 MB segments), the proto-ID is {context, ea[45:28]} and is 37 bits wide. The result is proto × 12538073 mod (2^37 - 1).
- R4: When `req_big`=1 (1 TB segments), the proto-ID is {context, ea[45:40]} and is 25 bits wide. The result is proto × 12538073 mod (2^25 - 1), and `res_segid[36:25]` is 0.
- R5: The result is always the canonical residue. Proto-ID 0 gives 0. Proto-ID 2^n - 1 gives 0. No result ever equals 2^n - 1.
- R6: When `req_kernel`=1, `req_ctx` is ignored and the context is 0x7FFFC + (ea[63:60] - 0xC). Regions 0xC, 0xD, 0xE and 0xF therefore give contexts 0x7FFFC, 0x7FFFD, 0x7FFFE and 0x7FFFF.
- R7: If ea[59:0] is at or above the range limit (default 2^46), the result is 0 and the error flag stays 0. An offset of 2^46 - 1 is translated normally.
- R8: In user mode, a context above 0x7FFFB sets `res_err` and gives a result of 0. Context 0x7FFFB itself is accepted without error.
- R9: A kernel-mode request never sets `res_err`.
- R10: In user mode, the address bits ea[63:60] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_ctx | input | 19 | User context number |
| req_ea | input | 64 | Effective address |
| req_big | input | 1 | Segment size: 0 = 256 MB, 1 = 1 TB |
| req_kernel | input | 1 | Derive the context from the address region |
| res_valid | output | 1 | Result present |
| res_segid | output | 37 | Scrambled segment ID |
| res_err | output | 1 | User context out of range |

## Verification
A wrong partial product or a stale pipeline register shows up as an incorrect `res_segid` three cycles after the request that used it. A fold that is missing its carry correction shows up only for products whose fold lands on or just past 2^n - 1. For that reason, proto-IDs next to the modulus are driven directly. A side flag that slips a stage shows up when a flagged request is followed back-to-back by a clean one: the zero result or the error flag lands on the wrong beat. Every result is compared against a direct modulo computation.

// File: rtl/segid_pkg.sv
package segid_pkg;

  // Per-request flags that travel with the data through the pipeline
  typedef struct packed {
    logic big;   // 1 TB segment selected
    logic kill;  // force result to zero
    logic err;   // user context out of range
  } seg_side_t;

endpackage

// File: rtl/segid_proto.sv
module segid_proto #(
  parameter int          CTX_W       = 19,
  parameter int          ESID_S_W    = 18,
  parameter int          ESID_L_W    = 6,
  parameter int          SHIFT_S     = 28,
  parameter int          SHIFT_L     = 40,
  parameter logic [63:0] RANGE_LIMIT = 64'h0000_4000_0000_0000,
  localparam int         PROTO_W     = CTX_W + ESID_S_W
) (
  input  logic [CTX_W-1:0]   ctx_i,
  input  logic [63:0]        ea_i,
  input  logic               big_i,
  input  logic               kernel_i,
  output logic [PROTO_W-1:0] proto_o,
  output logic               kill_o,
  output logic               err_o
);

  localparam logic [CTX_W-1:0] MAX_USER  = CTX_W'((1 << CTX_W) - 5);
  localparam logic [CTX_W-1:0] KERN_BASE = CTX_W'((1 << CTX_W) - 4);

  logic [4:0]          region_off;
  logic [CTX_W-1:0]    ctx_sel;
  logic [ESID_S_W-1:0] esid_s;
  logic [ESID_L_W-1:0] esid_l;
  logic                out_of_range;

  always_comb begin
    // signed offset of the region from 0xC, sign-extended into the context
    region_off   = {1'b0, ea_i[63:60]} - 5'd12;
    ctx_sel      = kernel_i ? KERN_BASE + {{(CTX_W-5){region_off[4]}}, region_off}
                            : ctx_i;
    esid_s       = ea_i[SHIFT_S +: ESID_S_W];
    esid_l       = ea_i[SHIFT_L +: ESID_L_W];
    out_of_range = ({4'b0, ea_i[59:0]} >= RANGE_LIMIT);
    err_o        = !kernel_i && (ctx_i > MAX_USER);
    kill_o       = err_o || out_of_range;
    if (big_i) proto_o = PROTO_W'({ctx_sel, esid_l});
    else       proto_o = {ctx_sel, esid_s};
  end

endmodule

// File: rtl/segid_mul_pipe.sv
module segid_mul_pipe
  import segid_pkg::*;
#(
  parameter int                IN_W   = 37,
  parameter int                MULT_W = 24,
  parameter logic [MULT_W-1:0] MULT   = 24'd12538073,
  parameter int                PART_W = 12,
  localparam int               PROD_W = IN_W + MULT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [IN_W-1:0]   in_data_i,
  input  seg_side_t         in_side_i,
  output logic              out_valid_o,
  output logic [PROD_W-1:0] out_prod_o,
  output seg_side_t         out_side_o
);

  localparam int PARTS = (MULT_W + PART_W - 1) / PART_W;
  localparam int PAD_W = PARTS * PART_W;
  localparam int PP_W  = IN_W + PART_W;
  localparam logic [PAD_W-1:0] MULT_PAD = PAD_W'(MULT);

  logic [PP_W-1:0]   pp_d [PARTS];
  logic [PP_W-1:0]   pp_q [PARTS];
  logic              v1_q, v1_d, v2_q, v2_d;
  seg_side_t         side1_q, side2_q;
  logic [PROD_W-1:0] sum_d, prod_q;

  // stage 1: one partial product per multiplier slice
  for (genvar gi = 0; gi < PARTS; gi++) begin : g_part
    localparam logic [PART_W-1:0] SLICE = MULT_PAD[gi*PART_W +: PART_W];
    assign pp_d[gi] = PP_W'(in_data_i) * PP_W'(SLICE);
  end

  // stage 2: weighted sum of the partial products
  always_comb begin
    sum_d = '0;
    for (int i = 0; i < PARTS; i++)
      sum_d = sum_d + (PROD_W'(pp_q[i]) << (i * PART_W));
  end

  always_comb begin
    v1_d = in_valid_i;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid_i) begin
      for (int i = 0; i < PARTS; i++) pp_q[i] <= pp_d[i];
      side1_q <= in_side_i;
    end
    if (v1_q) begin
      prod_q  <= sum_d;
      side2_q <= side1_q;
    end
  end

  assign out_valid_o = v2_q;
  assign out_prod_o  = prod_q;
  assign out_side_o  = side2_q;

  // R3: a zero operand leaves the pipe as a zero product two edges later
  p_zero_prod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_data_i == '0) |-> ##2 (out_valid_o && out_prod_o == '0));

endmodule

// File: rtl/segid_fold.sv
module segid_fold #(
  parameter int N    = 37,
  parameter int IN_W = 61
) (
  input  logic [IN_W-1:0] prod_i,
  output logic [N-1:0]    res_o
);

  localparam int HI_W = IN_W - N;
  localparam int XW   = ((HI_W > N) ? HI_W : N) + 1;

  logic [XW-1:0] x_sum, x_inc, y_sum;

  // end-around fold, then add the carry out of x+1 to skip the all-ones value
  always_comb begin
    x_sum = XW'(prod_i[IN_W-1:N]) + XW'(prod_i[N-1:0]);
    x_inc = x_sum + XW'(1);
    y_sum = x_sum + (x_inc >> N);
    res_o = y_sum[N-1:0];
  end

endmodule

// File: rtl/segid_scrambler.sv
module segid_scrambler
  import segid_pkg::*;
#(
  parameter int                CTX_W       = 19,
  parameter int                ESID_S_W    = 18,
  parameter int                ESID_L_W    = 6,
  parameter int                SHIFT_S     = 28,
  parameter int                SHIFT_L     = 40,
  parameter int                MULT_W      = 24,
  parameter logic [MULT_W-1:0] MULT        = 24'd12538073,
  parameter int                PART_W      = 12,
  parameter logic [63:0]       RANGE_LIMIT = 64'h0000_4000_0000_0000,
  localparam int               N_S         = CTX_W + ESID_S_W,
  localparam int               N_L         = CTX_W + ESID_L_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [63:0]      req_ea,
  input  logic             req_big,
  input  logic             req_kernel,
  output logic             res_valid,
  output logic [N_S-1:0]   res_segid,
  output logic             res_err
);

  localparam int PROD_W = N_S + MULT_W;

  logic              rdy_q, rdy_d, accept;
  logic [N_S-1:0]    proto;
  logic              kill, err;
  seg_side_t         side_in, mside;
  logic              mvalid;
  logic [PROD_W-1:0] prod;
  logic [N_S-1:0]    res_s, seg_d, seg_q;
  logic [N_L-1:0]    res_l;
  logic              err_d, err_q, val_q, val_d;

  always_comb begin
    rdy_d  = 1'b1;
    accept = req_valid && rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  segid_proto #(
    .CTX_W(CTX_W), .ESID_S_W(ESID_S_W), .ESID_L_W(ESID_L_W),
    .SHIFT_S(SHIFT_S), .SHIFT_L(SHIFT_L), .RANGE_LIMIT(RANGE_LIMIT)
  ) u_proto (
    .ctx_i(req_ctx), .ea_i(req_ea), .big_i(req_big), .kernel_i(req_kernel),
    .proto_o(proto), .kill_o(kill), .err_o(err)
  );

  always_comb side_in = '{big: req_big, kill: kill, err: err};

  segid_mul_pipe #(
    .IN_W(N_S), .MULT_W(MULT_W), .MULT(MULT), .PART_W(PART_W)
  ) u_mul (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(accept), .in_data_i(proto), .in_side_i(side_in),
    .out_valid_o(mvalid), .out_prod_o(prod), .out_side_o(mside)
  );

  segid_fold #(.N(N_S), .IN_W(PROD_W)) u_fold_s (.prod_i(prod), .res_o(res_s));
  segid_fold #(.N(N_L), .IN_W(PROD_W)) u_fold_l (.prod_i(prod), .res_o(res_l));

  // stage 3: select the fold for the segment size, apply the kill flag
  always_comb begin
    val_d = mvalid;
    err_d = mside.err;
    if (mside.kill)     seg_d = '0;
    else if (mside.big) seg_d = N_S'(res_l);
    else                seg_d = res_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= 1'b0;
    else        val_q <= val_d;
  end

  always_ff @(posedge clk) begin
    if (mvalid) begin
      seg_q <= seg_d;
      err_q <= err_d;
    end
  end

  assign req_ready = rdy_q;
  assign res_valid = val_q;
  assign res_segid = seg_q;
  assign res_err   = err_q;

  // R1: once ready, stays ready
  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  // R2: every accepted request yields a result three edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##3 res_valid);

  // R2: no result without a matching request
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid && req_ready, 3));

  // R4: a 1 TB result fits in the narrow width
  p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(req_big, 3)) |-> (res_segid[N_S-1:N_L] == '0));

  // R5: the all-ones residue never appears
  p_canonical_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_segid != {N_S{1'b1}} &&
                   !($past(req_big, 3) && res_segid[N_L-1:0] == {N_L{1'b1}})));

  // R8: an error always comes with a zero ID
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_segid == '0));

  // R9: kernel requests never flag an error
  p_kernel_noerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(req_kernel, 3)) |-> !res_err);

endmodule

// File: tb/tb_segid_scrambler.sv
module tb_segid_scrambler;

  localparam longint unsigned MULTC = 64'd12538073;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [18:0] req_ctx;
  logic [63:0] req_ea;
  logic        req_big;
  logic        req_kernel;
  logic        res_valid;
  logic [36:0] res_segid;
  logic        res_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // batch of queued requests
  logic [18:0] b_ctx  [16];
  logic [63:0] b_ea   [16];
  logic        b_big  [16];
  logic        b_kern [16];
  int          b_n = 0;

  always #2 clk = ~clk;  // 250 MHz

  segid_scrambler dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_ea(req_ea), .req_big(req_big), .req_kernel(req_kernel),
    .res_valid(res_valid), .res_segid(res_segid), .res_err(res_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent reference model
  task automatic model(input logic [18:0] ctx, input logic [63:0] ea, input logic big,
                       input logic kern, output logic [36:0] seg, output logic err);
    logic [18:0]     c;
    longint unsigned proto, modv;
    bit              oor;
    c   = kern ? 19'(32'h7FFFC + int'(ea[63:60]) - 12) : ctx;
    err = !kern && (ctx > 19'h7FFFB);
    oor = ea[59:0] >= 60'h0000_4000_0000_0000;
    if (big) begin
      proto = (longint'(c) << 6) | longint'(ea[45:40]);
      modv  = (64'd1 << 25) - 1;
    end else begin
      proto = (longint'(c) << 18) | longint'(ea[45:28]);
      modv  = (64'd1 << 37) - 1;
    end
    if (err || oor) seg = '0;
    else            seg = 37'((proto * MULTC) % modv);
  endtask

  task automatic add(input logic [18:0] ctx, input logic [63:0] ea,
                     input logic big, input logic kern);
    b_ctx[b_n] = ctx; b_ea[b_n] = ea; b_big[b_n] = big; b_kern[b_n] = kern;
    b_n++;
  endtask

  // drive the batch back-to-back and check each result three edges later
  task automatic run_batch(input string req);
    logic [36:0] es;
    logic        ee;
    for (int i = 0; i <= b_n + 3; i++) begin
      @(negedge clk);
      if (i >= 3 && i - 3 < b_n) begin
        model(b_ctx[i-3], b_ea[i-3], b_big[i-3], b_kern[i-3], es, ee);
        check({req, " valid"}, 64'(res_valid), 64'd1);
        check({req, " segid"}, 64'(res_segid), 64'(es));
        check({req, " err"},   64'(res_err),   64'(ee));
      end else begin
        check("R2 idle valid", 64'(res_valid), 64'd0);
      end
      if (i < b_n) begin
        req_valid = 1'b1; req_ctx = b_ctx[i]; req_ea = b_ea[i];
        req_big = b_big[i]; req_kernel = b_kern[i];
      end else begin
        req_valid = 1'b0;
      end
    end
    b_n = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_ctx = '0; req_ea = '0;
    req_big = 1'b0; req_kernel = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(req_ready), 64'd0);
    check("R1 valid in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 64'(req_ready), 64'd1);
  endtask

  task automatic t_small();
    add(19'h00001, 64'h0000_0000_1000_0000, 1'b0, 1'b0);
    add(19'h12345, 64'h0000_1234_5678_9ABC, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++)
      add(19'($urandom % 32'h7FFFC), {$urandom, $urandom} & 64'h0000_3FFF_FFFF_FFFF,
          1'b0, 1'b0);
    run_batch("R3 256MB");
  endtask

  task automatic t_big();
    add(19'h00001, 64'h0000_0100_0000_0000, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++)
      add(19'($urandom % 32'h7FFFC), {$urandom, $urandom} & 64'h0000_3FFF_FFFF_FFFF,
          1'b1, 1'b0);
    run_batch("R4 1TB");
  endtask

  task automatic t_boundary();
    add(19'h0, 64'h0, 1'b0, 1'b0);                      // proto 0
    add(19'h0, 64'h0, 1'b1, 1'b0);
    add(19'h0, 64'hF000_3FFF_E000_0000, 1'b0, 1'b1);    // 2^37-2
    add(19'h0, 64'hF000_3FFF_F000_0000, 1'b0, 1'b1);    // 2^37-1
    add(19'h0, 64'hF000_3E00_0000_0000, 1'b1, 1'b1);    // 2^25-2
    add(19'h0, 64'hF000_3F00_0000_0000, 1'b1, 1'b1);    // 2^25-1
    run_batch("R5 boundary");
  endtask

  task automatic t_kernel();
    add(19'h00000, 64'hC000_0000_3000_0000, 1'b0, 1'b1);
    add(19'h7FFFF, 64'hD000_0012_3000_0000, 1'b0, 1'b1);
    add(19'h55555, 64'hE000_2000_0000_0000, 1'b1, 1'b1);
    add(19'h7FFFE, 64'hF000_0ABC_D000_0000, 1'b0, 1'b1);
    run_batch("R6 R9 kernel");
  endtask

  task automatic t_range();
    add(19'h00042, 64'h0000_4000_0000_0000, 1'b0, 1'b0);
    add(19'h00042, 64'h0000_3FFF_FFFF_FFFF, 1'b0, 1'b0);
    add(19'h00042, 64'h0800_0000_0000_0000, 1'b1, 1'b0);
    add(19'h00042, 64'hC000_4000_0000_0000, 1'b0, 1'b1);
    run_batch("R7 range");
    add(19'h00042, 64'hA000_1234_5000_0000, 1'b0, 1'b0);
    add(19'h00042, 64'h5000_1234_5000_0000, 1'b1, 1'b0);
    run_batch("R10 region ignored");
  endtask

  task automatic t_user_limit();
    add(19'h7FFFB, 64'h0000_0000_5000_0000, 1'b0, 1'b0);
    add(19'h7FFFC, 64'h0000_0000_5000_0000, 1'b0, 1'b0);
    add(19'h7FFFF, 64'h0000_0100_0000_0000, 1'b1, 1'b0);
    add(19'h7FFFB, 64'h0000_0100_0000_0000, 1'b1, 1'b0);
    run_batch("R8 user limit");
  endtask

  task automatic t_stream();
    for (int k = 0; k < 16; k++)
      add(19'($urandom % 32'h80000), {$urandom, $urandom} & 64'hF000_7FFF_FFFF_FFFF,
          1'($urandom), 1'($urandom));
    run_batch("R2 stream");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5E61D));
    t_reset();
    t_small();
    t_big();
    t_boundary();
    t_kernel();
    t_range();
    t_user_limit();
    t_stream();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule